// File: doc/BRIEF.md
# Timer Control Word with Cross-Domain Enable and Soft Reset

This block is the register front end of a timer/counter. It offers a simple bus port (valid, write, address, write data, combinational read data) onto four registers: the 32-bit control word, a read-only status word with two synchronization busy flags, a debug register and an auxiliary configuration register. The enable bit and the soft-reset bit of the control word are carried into the slower counter clock domain through toggle handshakes. Each handshake returns an acknowledge that clears its busy flag.

The configuration fields of the control word are enable-protected. They take a written value only while the stored enable bit is 0. A soft-reset write overrides every other bit of the same access. While it is in flight, the control word reads as 0x0000_0001, and the debug and auxiliary registers refuse access. When the handshake completes, the control word and the auxiliary register return to zero, the counter-side enable drops, and the debug register keeps its value.

Top module: `timer_ctrl_sync`

## Requirements
- R1: After reset, every register reads 0, the status word reads 0 and `cnt_enable` is 0.
- R2: Only bits 29:24, 23, 16, 14:8, 6:5, 1 and 0 of the control word exist (mask 0x3F81_7F63), and the other bits always read 0. All bits except 1 (enable) and 0 (soft reset) are protected, and they take the written value when the stored enable bit is 0.
- R3: A control write with bit 0 set, accepted while no soft reset is busy, leaves the control word at exactly 0x0000_0001 and discards all other written bits.
- R4: A control write with bit 0 clear updates bit 1 in the next cycle and sets status bit 1 (enable busy).
- R5: With both clocks equal and in phase, `cnt_enable` takes the new enable value 3 clock edges after the write edge, and status bit 1 stays set for exactly 5 cycles after that edge.
- R6: While the stored enable bit is 1, a control write leaves the protected bits unchanged, and the enable bit still updates.
- R7: Control bit 0 and status bit 0 (soft-reset busy) fall in the same cycle, 5 cycles after the soft-reset write. At that point the control word and the auxiliary register (address 3) are 0 and `cnt_enable` is 0.
- R8: While soft reset is busy, an access to the debug register (address 2) or the auxiliary register (address 3) raises `bus_refused`, reads 0 and writes nothing. The status word (address 1) and the control word (address 0) stay readable. Control writes in that window are ignored without refusal.
- R9: The debug register (address 2, 8 bits) keeps its value across a soft reset.
- R10: A control write with bit 0 clear starts no soft reset, so status bit 0 stays 0.
- R11: A control write made while enable busy is set leaves the enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| cnt_clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | 0 control, 1 status, 2 debug, 3 auxiliary |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when refused |
| bus_refused | output | 1 | Access refused because soft reset is busy |
| ctrl_word | output | 32 | Current control word |
| cnt_enable | output | 1 | Enable in the counter clock domain |
| cnt_swrst_pulse | output | 1 | One-cycle reset pulse in the counter clock domain |

## Verification
The assertions check these invariants on every cycle:
- the soft-reset bit always matches its busy flag;
- unimplemented control bits stay 0;
- protected fields never move while enabled;
- a soft-reset write always leaves exactly 0x0000_0001;
- an accepted enable write is echoed with busy set;
- refused accesses return 0.

Only the bench scenarios can show the cycle counts of the two handshakes, the counter-side enable following the bus-side value, and the blocked writes having left no trace. They can also show the auxiliary register cleared, and the debug register kept, after a reset.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int unsigned CTRL_W = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DBG_W  = 8;
  localparam int unsigned AUX_W  = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DBG  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_AUX  = 2'd3;

  localparam int unsigned SWRST_BIT = 0;
  localparam int unsigned EN_BIT    = 1;

  // handshake indices (also status word bit positions)
  localparam int unsigned HS_SW = 0;
  localparam int unsigned HS_EN = 1;
  localparam int unsigned HS_N  = 2;

  localparam logic [CTRL_W-1:0] F_CAPT    = 32'h3F00_0000;
  localparam logic [CTRL_W-1:0] F_DMA1    = 32'h0080_0000;
  localparam logic [CTRL_W-1:0] F_FULLCYC = 32'h0001_0000;
  localparam logic [CTRL_W-1:0] F_ALOCK   = 32'h0000_4000;
  localparam logic [CTRL_W-1:0] F_PSYNC   = 32'h0000_3000;
  localparam logic [CTRL_W-1:0] F_STBY    = 32'h0000_0800;
  localparam logic [CTRL_W-1:0] F_PRESC   = 32'h0000_0700;
  localparam logic [CTRL_W-1:0] F_DITHER  = 32'h0000_0060;

  localparam logic [CTRL_W-1:0] PROT_MASK = F_CAPT | F_DMA1 | F_FULLCYC | F_ALOCK |
                                            F_PSYNC | F_STBY | F_PRESC | F_DITHER;
  localparam logic [CTRL_W-1:0] SWRST_MASK = CTRL_W'(1) << SWRST_BIT;
  localparam logic [CTRL_W-1:0] EN_MASK    = CTRL_W'(1) << EN_BIT;
  localparam logic [CTRL_W-1:0] IMPL_MASK  = PROT_MASK | SWRST_MASK | EN_MASK;
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tcr_handshake.sv
module tcr_handshake #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic dst_clk,
  input  logic dst_rst_n,
  input  logic launch,
  output logic busy,
  output logic done,
  output logic dst_fire
);
  logic req_q, req_d;
  logic req_dst;
  logic seen_q, seen_d;
  logic ack_pre;
  logic ack_q, ack_d;

  // source side: request toggle and returning acknowledge
  always_comb begin
    req_d = req_q ^ launch;
    ack_d = ack_pre;
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      if (launch) req_q <= req_d;
      ack_q <= ack_d;
    end
  end

  tcr_sync #(.W(1), .STAGES(STAGES)) u_fwd (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_q), .q(req_dst)
  );

  // destination side: edge detect on the synchronized toggle
  assign seen_d = req_dst;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) seen_q <= 1'b0;
    else            seen_q <= seen_d;
  end

  assign dst_fire = req_dst ^ seen_q;

  tcr_sync #(.W(1), .STAGES(STAGES-1)) u_bwd (
    .clk(src_clk), .rst_n(src_rst_n), .d(seen_q), .q(ack_pre)
  );

  assign busy = req_q ^ ack_q;
  assign done = busy & ~(ack_pre ^ req_q);
endmodule

// File: rtl/tcr_ctrl_regs.sv
module tcr_ctrl_regs
  import tcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  input  logic [HS_N-1:0]   hs_busy,
  input  logic [HS_N-1:0]   hs_done,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] rdata,
  output logic              refused,
  output logic [HS_N-1:0]   hs_launch
);
  logic              sw_busy, sw_done, en_free;
  logic              sel_ctrl, sel_stat, sel_dbg, sel_aux;
  logic              wr_ok, ctrl_wr;
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;
  logic [DBG_W-1:0]  dbg_q, dbg_d;
  logic              dbg_en;
  logic [AUX_W-1:0]  aux_q, aux_d;
  logic              aux_en;

  assign sw_busy = hs_busy[HS_SW];
  assign sw_done = hs_done[HS_SW];
  // enable channel is free when idle or when its acknowledge lands this edge
  assign en_free = ~hs_busy[HS_EN] | hs_done[HS_EN];

  always_comb begin
    sel_ctrl = (bus_addr == ADDR_CTRL);
    sel_stat = (bus_addr == ADDR_STAT);
    sel_dbg  = (bus_addr == ADDR_DBG);
    sel_aux  = (bus_addr == ADDR_AUX);
    refused  = bus_valid & sw_busy & (sel_dbg | sel_aux);
    wr_ok    = bus_valid & bus_write & ~refused;
    ctrl_wr  = wr_ok & sel_ctrl & ~sw_busy;

    hs_launch        = '0;
    hs_launch[HS_SW] = ctrl_wr & bus_wdata[SWRST_BIT];
    hs_launch[HS_EN] = ctrl_wr & ~bus_wdata[SWRST_BIT] & en_free;

    ctrl_d  = ctrl_q;
    ctrl_en = 1'b0;
    if (sw_done) begin
      ctrl_d  = '0;
      ctrl_en = 1'b1;
    end else if (hs_launch[HS_SW]) begin
      ctrl_d  = SWRST_MASK;
      ctrl_en = 1'b1;
    end else if (ctrl_wr) begin
      ctrl_en = 1'b1;
      ctrl_d  = ctrl_q[EN_BIT] ? (ctrl_q & PROT_MASK) : (bus_wdata & PROT_MASK);
      ctrl_d[EN_BIT] = en_free ? bus_wdata[EN_BIT] : ctrl_q[EN_BIT];
    end

    aux_d  = aux_q;
    aux_en = 1'b0;
    if (sw_done) begin
      aux_d  = '0;
      aux_en = 1'b1;
    end else if (wr_ok & sel_aux) begin
      aux_d  = bus_wdata[AUX_W-1:0];
      aux_en = 1'b1;
    end

    dbg_en = wr_ok & sel_dbg;
    dbg_d  = bus_wdata[DBG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      aux_q  <= '0;
      dbg_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (aux_en)  aux_q  <= aux_d;
      if (dbg_en)  dbg_q  <= dbg_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (bus_valid & ~bus_write & ~refused) begin
      if (sel_ctrl) rdata = ctrl_q;
      if (sel_stat) rdata[HS_N-1:0] = hs_busy;
      if (sel_dbg)  rdata[DBG_W-1:0] = dbg_q;
      if (sel_aux)  rdata[AUX_W-1:0] = aux_q;
    end
  end
endmodule

// File: rtl/tcr_cnt_side.sv
module tcr_cnt_side (
  input  logic cnt_clk,
  input  logic cnt_rst_n,
  input  logic en_fire,
  input  logic sw_fire,
  input  logic en_level,
  output logic cnt_enable,
  output logic cnt_swrst_pulse
);
  logic en_d, pulse_d;

  always_comb begin
    en_d = cnt_enable;
    if (sw_fire)      en_d = 1'b0;
    else if (en_fire) en_d = en_level;
    pulse_d = sw_fire;
  end

  always_ff @(posedge cnt_clk or negedge cnt_rst_n) begin
    if (!cnt_rst_n) begin
      cnt_enable      <= 1'b0;
      cnt_swrst_pulse <= 1'b0;
    end else begin
      cnt_enable      <= en_d;
      cnt_swrst_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/timer_ctrl_sync.sv
module timer_ctrl_sync
  import tcr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              cnt_clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  output logic              bus_refused,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              cnt_enable,
  output logic              cnt_swrst_pulse
);
  logic            bus_rst_n, cnt_rst_n;
  logic [HS_N-1:0] hs_launch, hs_busy, hs_done, hs_fire;
  logic            sw_busy, en_busy;

  tcr_sync #(.W(1), .STAGES(2)) u_bus_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(bus_rst_n)
  );
  tcr_sync #(.W(1), .STAGES(2)) u_cnt_rst (
    .clk(cnt_clk), .rst_n(rst_n), .d(1'b1), .q(cnt_rst_n)
  );

  tcr_ctrl_regs u_regs (
    .clk(clk), .rst_n(bus_rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .hs_busy(hs_busy), .hs_done(hs_done),
    .ctrl_q(ctrl_word), .rdata(bus_rdata), .refused(bus_refused),
    .hs_launch(hs_launch)
  );

  for (genvar g = 0; g < HS_N; g++) begin : g_hs
    tcr_handshake #(.STAGES(SYNC_STAGES)) u_hs (
      .src_clk(clk), .src_rst_n(bus_rst_n),
      .dst_clk(cnt_clk), .dst_rst_n(cnt_rst_n),
      .launch(hs_launch[g]), .busy(hs_busy[g]),
      .done(hs_done[g]), .dst_fire(hs_fire[g])
    );
  end

  assign sw_busy = hs_busy[HS_SW];
  assign en_busy = hs_busy[HS_EN];

  tcr_cnt_side u_cnt (
    .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
    .en_fire(hs_fire[HS_EN]), .sw_fire(hs_fire[HS_SW]),
    .en_level(ctrl_word[EN_BIT]),
    .cnt_enable(cnt_enable), .cnt_swrst_pulse(cnt_swrst_pulse)
  );
endmodule

// File: rtl/timer_ctrl_sync_chk.sv
module timer_ctrl_sync_chk
  import tcr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CTRL_W-1:0] bus_wdata,
  input logic [CTRL_W-1:0] bus_rdata,
  input logic              bus_refused,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              sw_busy,
  input logic              en_busy
);
  // R7
  swrst_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[SWRST_BIT] == sw_busy);

  // R3
  swrst_precedence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_CTRL && bus_wdata[SWRST_BIT] && !sw_busy)
    |=> (ctrl_word == SWRST_MASK));

  // R6
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_word[EN_BIT]) && !$past(ctrl_word[SWRST_BIT]) && !ctrl_word[SWRST_BIT])
    |-> ((ctrl_word & PROT_MASK) == ($past(ctrl_word) & PROT_MASK)));

  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word & ~IMPL_MASK) == '0);

  // R4
  enable_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_CTRL && !bus_wdata[SWRST_BIT] && !sw_busy && !en_busy)
    |=> (ctrl_word[EN_BIT] == $past(bus_wdata[EN_BIT]) && en_busy));

  // R8
  refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && sw_busy && (bus_addr == ADDR_DBG || bus_addr == ADDR_AUX))
    |-> (bus_refused && bus_rdata == '0));
endmodule

bind timer_ctrl_sync timer_ctrl_sync_chk u_chk (
  .clk(clk), .rst_n(bus_rst_n),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_refused(bus_refused),
  .ctrl_word(ctrl_word), .sw_busy(sw_busy), .en_busy(en_busy)
);

// File: tb/timer_ctrl_sync_tb.sv
module timer_ctrl_sync_tb;
  import tcr_pkg::*;

  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        cnt_clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, ctrl_word;
  logic        bus_refused, cnt_enable, cnt_swrst_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CLK_PERIOD/2) cnt_clk = ~cnt_clk;

  timer_ctrl_sync u_dut (
    .clk(clk), .cnt_clk(cnt_clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_refused(bus_refused),
    .ctrl_word(ctrl_word), .cnt_enable(cnt_enable), .cnt_swrst_pulse(cnt_swrst_pulse)
  );

  typedef struct {
    bit          is_read;
    logic [31:0] data;
    bit          refused;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic bus_op(bit wr, logic [1:0] a, logic [31:0] d,
                        logic [31:0] exp, bit exp_ref, string tag);
    sb_item_t it;
    it.is_read = !wr;
    it.data    = exp;
    it.refused = exp_ref;
    it.tag     = tag;
    sb_q.push_back(it);
    bus_valid = 1'b1;
    bus_write = wr;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, bit exp_ref, string tag);
    bus_op(1'b1, a, d, 32'h0, exp_ref, tag);
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, bit exp_ref, string tag);
    bus_op(1'b0, a, 32'h0, exp, exp_ref, tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each access against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_valid === 1'b1) begin
        if (sb_q.size() == 0) begin
          n_chk++;
          n_fail++;
          $display("FAIL scoreboard empty actual=0x%08h expected=none", bus_rdata);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          if (it.is_read) chk(it.tag, bus_rdata, it.data);
          chk({it.tag, " refused"}, 32'(bus_refused), 32'(it.refused));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = 2'd0;
    bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 cnt_enable", 32'(cnt_enable), 32'h0);
    rd(ADDR_CTRL, 32'h0, 1'b0, "R1 ctrl");
    rd(ADDR_STAT, 32'h0, 1'b0, "R1 status");
    rd(ADDR_DBG,  32'h0, 1'b0, "R1 debug");
    rd(ADDR_AUX,  32'h0, 1'b0, "R1 aux");

    // R2 R4 R5: enable with all fields while disabled
    wr(ADDR_CTRL, 32'hFFFF_FFFE, 1'b0, "R2 write all");
    for (int k = 0; k < 6; k++) begin
      chk("R5 cnt_enable rise", 32'(cnt_enable), (k >= 3) ? 32'h1 : 32'h0);
      rd(ADDR_STAT, (k < 5) ? 32'h2 : 32'h0, 1'b0, "R4 R5 enable busy");
    end
    rd(ADDR_CTRL, 32'h3F81_7F62, 1'b0, "R2 implemented mask");

    // R6: protected fields frozen while enabled
    wr(ADDR_CTRL, 32'h0000_0002, 1'b0, "R6 write keep enable");
    idle(6);
    rd(ADDR_CTRL, 32'h3F81_7F62, 1'b0, "R6 protected held");
    wr(ADDR_CTRL, 32'h0000_0000, 1'b0, "R6 disable");
    rd(ADDR_CTRL, 32'h3F81_7F60, 1'b0, "R4 R6 enable echo");
    idle(6);
    chk("R5 cnt_enable fall", 32'(cnt_enable), 32'h0);

    // R2: protected fields writable while disabled
    wr(ADDR_CTRL, 32'h0000_0120, 1'b0, "R2 write while disabled");
    rd(ADDR_CTRL, 32'h0000_0120, 1'b0, "R2 fields update");
    idle(6);
    wr(ADDR_AUX, 32'h1234_5678, 1'b0, "R1 aux write");
    wr(ADDR_DBG, 32'h0000_00A5, 1'b0, "R9 debug write");
    rd(ADDR_AUX, 32'h1234_5678, 1'b0, "R1 aux readback");
    rd(ADDR_DBG, 32'h0000_00A5, 1'b0, "R9 debug readback");

    // R11: enable write during enable busy
    wr(ADDR_CTRL, 32'h0000_0122, 1'b0, "R11 enable");
    wr(ADDR_CTRL, 32'h0000_0020, 1'b0, "R11 write while busy");
    rd(ADDR_CTRL, 32'h0000_0122, 1'b0, "R11 enable kept");
    idle(6);
    chk("R5 cnt_enable on", 32'(cnt_enable), 32'h1);

    // R3 R7 R8: soft reset
    wr(ADDR_CTRL, 32'hFFFF_FFFF, 1'b0, "R3 soft reset");
    rd(ADDR_CTRL, 32'h0000_0001, 1'b0, "R3 precedence");
    rd(ADDR_STAT, 32'h0000_0001, 1'b0, "R8 status readable");
    rd(ADDR_AUX,  32'h0, 1'b1, "R8 aux refused");
    wr(ADDR_DBG,  32'h0000_005A, 1'b1, "R8 debug write refused");
    wr(ADDR_CTRL, 32'h0000_0002, 1'b0, "R8 ctrl write ignored");
    rd(ADDR_STAT, 32'h0, 1'b0, "R7 busy cleared after 5");
    rd(ADDR_CTRL, 32'h0, 1'b0, "R7 ctrl cleared");
    chk("R7 cnt_enable off", 32'(cnt_enable), 32'h0);
    rd(ADDR_AUX, 32'h0, 1'b0, "R7 aux cleared");
    rd(ADDR_DBG, 32'h0000_00A5, 1'b0, "R9 debug kept");

    // R10: bit 0 clear starts nothing
    wr(ADDR_CTRL, 32'h0000_0060, 1'b0, "R10 write");
    rd(ADDR_CTRL, 32'h0000_0060, 1'b0, "R10 ctrl");
    rd(ADDR_STAT, 32'h0000_0002, 1'b0, "R10 no soft reset busy");

    idle(8);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule